// File: doc/BRIEF.md
# Table-Indexed Branch Target Unit

This unit works out the next program counter for two control transfers whose destination sits in a table in memory. In the register-indexed jump, the table starts at the halfword just after the current instruction. The index register selects a signed halfword entry, and that entry is a doubled displacement measured from the table start. In the table call, a control register holds the table base. A 6-bit immediate selects an unsigned halfword entry, and that entry is a plain offset from the same base.

A transfer starts with a one-cycle `start_i`. The unit then sends one halfword read to a memory port and waits for the data. When the data arrives it computes the destination and raises `done_o` for one cycle. The destination stays on `target_o` until the next transfer completes. Only one read is ever in flight.

Top module: `tbl_branch_unit`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `mem_req_o` are 0 and `target_o` is 0.
- R2: When `start_i` is sampled high while idle with `kind_i`=0 (register-indexed jump), `mem_req_o` is high in the next cycle only, and `mem_addr_o` = `cur_pc_i` + 2 + (`index_i` << 1).
- R3: When `start_i` is sampled high while idle with `kind_i`=1 (table call), `mem_req_o` is high in the next cycle only, and `mem_addr_o` = `call_base_i` + (`imm6_i` << 1), with the immediate taken unsigned.
- R4: For a jump, the destination is `cur_pc_i` + 2 + (sign-extended `mem_rdata_i` << 1), with bit 0 forced to 0.
- R5: For a call, the destination is `call_base_i` + zero-extended `mem_rdata_i`, with bit 0 forced to 0.
- R6: While `busy_o` is high, `start_i` is ignored. No new request is issued, and the transfer in progress completes with its original operands.
- R7: `mem_rvalid_i` is accepted in any cycle after the request cycle. `done_o` is high for exactly the cycle after the accepting edge, with the destination on `target_o`. `target_o` holds that value until the next completion.
- R8: `mem_rvalid_i` is ignored when no read is outstanding. It raises no `done_o` and does not change `target_o`.
- R9: All address and destination sums are 32-bit and wrap modulo 2^32.
- R10: Bit 0 of `target_o` is 0 on every completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a transfer (sampled when idle) |
| kind_i | input | 1 | 0 = register-indexed jump, 1 = table call |
| cur_pc_i | input | 32 | Address of the current instruction |
| index_i | input | 32 | Index register value (jump) |
| imm6_i | input | 6 | Table slot immediate (call) |
| call_base_i | input | 32 | Call-table base register value |
| mem_req_o | output | 1 | One-cycle read request |
| mem_addr_o | output | 32 | Halfword entry address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 16 | Fetched table entry |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion strobe |
| target_o | output | 32 | Computed destination |

## Verification
The bench aims at the sign bit of the jump entry. Entry 0x8000 must move backwards, so a design that zero-extends it would jump far forward. It also aims at 0xFFFF in the call table, where a design that sign-extends it would land just below the base. Program counters and bases near the top of the address space check the wrap; a design that keeps a carry or clamps the sum would give a wrong address. Odd bases and odd program counters show whether bit 0 is cleared.

Extra `start_i` pulses are driven during a wait, and stray `mem_rvalid_i` pulses are driven while idle. A design that restarts on the first would issue a second request or use the new operands. A design that accepts the second would raise `done_o` or overwrite the held destination.

// File: rtl/tbl_branch_pkg.sv
package tbl_branch_pkg;
  parameter int ADDR_W = 32;
  parameter int HALF_W = 16;
  parameter int IMM_W  = 6;

  typedef enum logic {XFER_JUMP = 1'b0, XFER_CALL = 1'b1} xfer_kind_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_ISSUE = 2'd1, ST_WAIT = 2'd2} seq_state_e;

  // Base used both for the entry address and for the destination.
  function automatic logic [ADDR_W-1:0] table_base(
      input xfer_kind_e k, input logic [ADDR_W-1:0] pc, input logic [ADDR_W-1:0] cbase);
    return (k == XFER_CALL) ? cbase : pc + ADDR_W'(2);
  endfunction

  function automatic logic [ADDR_W-1:0] entry_addr(
      input xfer_kind_e k, input logic [ADDR_W-1:0] base,
      input logic [ADDR_W-1:0] idx, input logic [IMM_W-1:0] imm);
    logic [ADDR_W-1:0] slot;
    slot = (k == XFER_CALL) ? ADDR_W'(imm) : idx;
    return base + (slot << 1);
  endfunction

  function automatic logic [ADDR_W-1:0] dest_addr(
      input xfer_kind_e k, input logic [ADDR_W-1:0] base, input logic [HALF_W-1:0] h);
    logic [ADDR_W-1:0] off;
    logic [ADDR_W-1:0] sum;
    if (k == XFER_CALL) off = ADDR_W'(h);
    else                off = ADDR_W'($signed(h)) << 1;
    sum = base + off;
    return {sum[ADDR_W-1:1], 1'b0};
  endfunction
endpackage

// File: rtl/tbu_seq.sv
module tbu_seq
  import tbl_branch_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic rvalid_i,
  output logic accept_o,
  output logic issue_o,
  output logic take_o,
  output logic busy_o
);
  seq_state_e state_q, state_d;

  assign accept_o = (state_q == ST_IDLE) && start_i;
  assign issue_o  = (state_q == ST_ISSUE);
  assign take_o   = (state_q == ST_WAIT) && rvalid_i;
  assign busy_o   = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_ISSUE;
      ST_ISSUE: state_d = ST_WAIT;
      ST_WAIT:  if (rvalid_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assert_req_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    issue_o |=> !issue_o);
  assert_busy_blocks_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> !issue_o);
  assert_idle_ignores_rvalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && rvalid_i) |-> !take_o);
endmodule

// File: rtl/tbu_operands.sv
module tbu_operands
  import tbl_branch_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int IW = IMM_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept_i,
  input  logic          kind_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] idx_i,
  input  logic [IW-1:0] imm_i,
  input  logic [AW-1:0] cbase_i,
  output xfer_kind_e    kind_o,
  output logic [AW-1:0] base_o,
  output logic [AW-1:0] addr_o
);
  xfer_kind_e    k;
  logic [AW-1:0] base_now;

  assign k        = xfer_kind_e'(kind_i);
  assign base_now = table_base(k, pc_i, cbase_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_o <= XFER_JUMP;
      base_o <= '0;
      addr_o <= '0;
    end else if (accept_i) begin
      kind_o <= k;
      base_o <= base_now;
      addr_o <= entry_addr(k, base_now, idx_i, imm_i);
    end
  end

  assert_operands_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_i |=> ($stable(base_o) && $stable(addr_o) && $stable(kind_o)));
endmodule

// File: rtl/tbu_result.sv
module tbu_result
  import tbl_branch_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int HW = HALF_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_i,
  input  xfer_kind_e    kind_i,
  input  logic [AW-1:0] base_i,
  input  logic [HW-1:0] half_i,
  output logic          done_o,
  output logic [AW-1:0] target_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_o   <= 1'b0;
      target_o <= '0;
    end else begin
      done_o <= take_i;
      if (take_i) target_o <= dest_addr(kind_i, base_i, half_i);
    end
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_target_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(target_o));
  assert_target_even_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (target_o[0] == 1'b0));
endmodule

// File: rtl/tbl_branch_unit.sv
module tbl_branch_unit
  import tbl_branch_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int HW = HALF_W,
  parameter int IW = IMM_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          kind_i,
  input  logic [AW-1:0] cur_pc_i,
  input  logic [AW-1:0] index_i,
  input  logic [IW-1:0] imm6_i,
  input  logic [AW-1:0] call_base_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_rvalid_i,
  input  logic [HW-1:0] mem_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] target_o
);
  logic          accept_w, take_w;
  xfer_kind_e    kind_w;
  logic [AW-1:0] base_w, addr_w;

  tbu_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rvalid_i(mem_rvalid_i),
    .accept_o(accept_w), .issue_o(mem_req_o), .take_o(take_w), .busy_o(busy_o));

  tbu_operands #(.AW(AW), .IW(IW)) u_ops (
    .clk(clk), .rst_n(rst_n), .accept_i(accept_w), .kind_i(kind_i),
    .pc_i(cur_pc_i), .idx_i(index_i), .imm_i(imm6_i), .cbase_i(call_base_i),
    .kind_o(kind_w), .base_o(base_w), .addr_o(addr_w));

  tbu_result #(.AW(AW), .HW(HW)) u_res (
    .clk(clk), .rst_n(rst_n), .take_i(take_w), .kind_i(kind_w),
    .base_i(base_w), .half_i(mem_rdata_i), .done_o(done_o), .target_o(target_o));

  assign mem_addr_o = addr_w;

  assert_req_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> $past(start_i && !busy_o));
  assert_done_after_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(mem_rvalid_i && busy_o && !mem_req_o));
endmodule

// File: tb/tbl_branch_unit_bench.sv
module tbl_branch_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, kind_i = 1'b0;
  logic [31:0] cur_pc_i = '0, index_i = '0, call_base_i = '0;
  logic [5:0]  imm6_i = '0;
  logic        mem_req_o, mem_rvalid_i = 1'b0, busy_o, done_o;
  logic [31:0] mem_addr_o, target_o;
  logic [15:0] mem_rdata_i = '0;
  int errors = 0, checks = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  tbl_branch_unit u_tbl_branch_unit (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] want_addr(input logic k, input logic [31:0] pc,
      input logic [31:0] idx, input logic [5:0] imm, input logic [31:0] cb);
    if (k) return cb + {25'd0, imm, 1'b0};
    return pc + 32'd2 + {idx[30:0], 1'b0};
  endfunction

  function automatic logic [31:0] want_dest(input logic k, input logic [31:0] pc,
      input logic [31:0] cb, input logic [15:0] h);
    logic [31:0] t;
    if (k) t = cb + {16'd0, h};
    else   t = pc + 32'd2 + {{15{h[15]}}, h, 1'b0};
    return t & 32'hFFFF_FFFE;
  endfunction

  // One transfer; lat = idle wait cycles before data; poke = extra start during wait.
  task automatic xfer(input logic k, input logic [31:0] pc, input logic [31:0] idx,
      input logic [5:0] imm, input logic [31:0] cb, input logic [15:0] h,
      input int lat, input bit poke);
    logic [31:0] ea, et;
    ea = want_addr(k, pc, idx, imm, cb);
    et = want_dest(k, pc, cb, h);
    @(negedge clk);
    start_i = 1'b1; kind_i = k; cur_pc_i = pc; index_i = idx; imm6_i = imm; call_base_i = cb;
    @(negedge clk);
    start_i = 1'b0;
    chk(k ? "R3 req" : "R2 req", {31'd0, mem_req_o}, 32'd1);
    chk(k ? "R3 addr" : "R2 addr", mem_addr_o, ea);
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      if (poke && i == 0) begin
        start_i = 1'b1; kind_i = ~k; cur_pc_i = ~pc; call_base_i = ~cb;
        @(negedge clk);
        start_i = 1'b0;
        chk("R6 no second req", {31'd0, mem_req_o}, 32'd0);
        chk("R6 busy", {31'd0, busy_o}, 32'd1);
      end
    end
    @(negedge clk);
    chk("R7 req single", {31'd0, mem_req_o}, 32'd0);
    mem_rvalid_i = 1'b1; mem_rdata_i = h;
    @(negedge clk);
    mem_rvalid_i = 1'b0; mem_rdata_i = ~h;
    chk("R7 done", {31'd0, done_o}, 32'd1);
    chk(k ? "R5 target" : "R4 target", target_o, et);
    chk("R10 bit0", {31'd0, target_o[0]}, 32'd0);
    @(negedge clk);
    chk("R7 done pulse", {31'd0, done_o}, 32'd0);
    chk("R7 held", target_o, et);
  endtask

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    chk("R1 busy", {31'd0, busy_o}, 32'd0);
    chk("R1 done", {31'd0, done_o}, 32'd0);
    chk("R1 req", {31'd0, mem_req_o}, 32'd0);
    chk("R1 target", target_o, 32'd0);
    rst_n = 1'b1;
    // Directed corners
    xfer(1'b0, 32'h0000_1000, 32'd3, 6'd0, 32'd0, 16'h8000, 0, 1'b0);       // R4 most negative
    xfer(1'b0, 32'hFFFF_FFFE, 32'h8000_0001, 6'd0, 32'd0, 16'h0004, 1, 1'b0); // R9 wrap
    xfer(1'b1, 32'd0, 32'd0, 6'd63, 32'h0000_2000, 16'hFFFF, 2, 1'b0);       // R5 unsigned top
    xfer(1'b1, 32'd0, 32'd0, 6'd5, 32'hFFFF_FFF1, 16'h0100, 0, 1'b0);        // R9 R10 odd base
    xfer(1'b0, 32'h0000_0333, 32'd0, 6'd0, 32'd0, 16'h7FFF, 3, 1'b1);        // R6 R10 odd pc
    // R8: stray data while idle
    held = target_o;
    @(negedge clk);
    mem_rvalid_i = 1'b1; mem_rdata_i = 16'h1234;
    @(negedge clk);
    mem_rvalid_i = 1'b0;
    chk("R8 no done", {31'd0, done_o}, 32'd0);
    chk("R8 busy", {31'd0, busy_o}, 32'd0);
    @(negedge clk);
    chk("R8 target kept", target_o, held);
    // Random mix
    void'($urandom(32'd1234));
    for (int n = 0; n < 60; n++) begin
      xfer(1'($urandom), $urandom, $urandom, 6'($urandom), $urandom, 16'($urandom),
           int'($urandom % 4), 1'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule